// File: doc/BRIEF.md
# Queued SPI transfer controller

This block is an SPI master that works through a list of transfers held in a small internal queue, without the host having to service each word. Every queue slot carries its own transmit word, the index of the peripheral select to drive, the word length and a pause that follows the word. When a transfer completes, the word clocked in from the peripheral replaces the transmit word in the same slot, so the queue doubles as a table of peripheral values that the host reads like memory.

The host fills slots through a write port while the controller is idle, sets the index of the last slot to use and pulses start. The controller runs slots 0 through the last index in order. In one-shot mode it then stops and holds a done flag. In wrap mode it goes back to slot 0 and keeps acquiring, pulsing a pass marker each time the list completes, until the host asks it to stop; the stop is honoured only between words. The serial side uses clock-idle-low, sample-on-rising-edge timing with the most significant bit first.

Top module: `qspi_ctrl`

## Requirements
- R1: While reset is applied and right after it, every select line is high, the serial clock is low, and busy, done and the write-error flag are low.
- R2: A host write stores the slot fields packed as {delay, select index, length minus one, data} with the data in the low DATA_W bits; the read port returns the data field of the addressed slot combinationally.
- R3: A transfer from a slot with length field n sends n+1 bits, the low n+1 data bits highest first; the serial clock idles low, each half period lasts HALF clock cycles, output data is set up before each rising edge and input data is taken on each rising edge.
- R4: During a transfer only the select line whose index the slot names is low, and it stays low across all of that word's clock pulses; never more than one select line is low.
- R5: After a transfer, the slot's data field holds the received bits right-aligned with zeros above them.
- R6: Between two consecutive transfers of a run, all select lines stay high for exactly the slot's delay plus 2 clock cycles, the delay taken from the slot that just finished.
- R7: A start while idle runs slots 0 to the last index in order; slots above it are neither sent nor changed; in one-shot mode the controller then goes idle and sets done, which stays set until the next start.
- R8: In wrap mode, after the last slot the controller continues with slot 0 and raises a one-cycle pass pulse at each such turn; done stays low.
- R9: A stop request during a run lets the current word finish at full length, starts no further word, and leaves done low.
- R10: A host write while busy changes no slot and sets the write-error flag, which stays set until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Slot write strobe |
| host_addr | input | IDX_W | Slot index for write and read |
| host_wdata | input | ENT_W | Packed slot fields {delay, select, length-1, data} |
| host_rdata | output | DATA_W | Data field of the addressed slot |
| start | input | 1 | Begin a run from slot 0 (ignored while busy) |
| stop | input | 1 | Request an end of run at the next word boundary |
| wrap_en | input | 1 | Restart from slot 0 after the last slot |
| last_idx | input | IDX_W | Index of the final slot of a pass |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Sticky: one-shot run completed |
| wrap_pulse | output | 1 | One-cycle marker at each pass turn in wrap mode |
| wr_err | output | 1 | Sticky: a slot write arrived while busy |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to peripherals |
| miso | input | 1 | Serial data from peripherals |
| cs_n | output | NUM_CS | Active-low peripheral selects |

## Verification
The bench builds the controller with 8-bit words, a 4-slot queue, 4 selects, 4-bit delays and a two-cycle half period. That small configuration lets a sweep of rounds reach every word length from 1 to 8, every select index, delays across the whole 0 to 15 range and every last-slot index, with a bench-side peripheral that returns a computed word for each transfer. A wrap-mode run then shows received words being retransmitted on the next pass, the pass marker count, a mid-word stop and a rejected write while busy.

// File: rtl/qspi_pkg.sv
package qspi_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_LOAD = 2'd1,
        SQ_XFER = 2'd2,
        SQ_GAP  = 2'd3
    } seq_st_t;

    function automatic int unsigned idx_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/qspi_queue.sv
module qspi_queue #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 16,
    parameter int LEN_W  = 4,
    parameter int CS_W   = 2,
    parameter int DLY_W  = 8,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [LEN_W-1:0]  wr_len,
    input  logic [CS_W-1:0]   wr_cs,
    input  logic [DLY_W-1:0]  wr_dly,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    input  logic [IDX_W-1:0]  eng_idx,
    output logic [DATA_W-1:0] eng_data,
    output logic [LEN_W-1:0]  eng_len,
    output logic [CS_W-1:0]   eng_cs,
    output logic [DLY_W-1:0]  eng_dly,
    input  logic              wb_en,
    input  logic [DATA_W-1:0] wb_data
);

    logic [DATA_W-1:0] dat_q [DEPTH];
    logic [LEN_W-1:0]  len_q [DEPTH];
    logic [CS_W-1:0]   cs_q  [DEPTH];
    logic [DLY_W-1:0]  dly_q [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        localparam logic [IDX_W-1:0] SLOT = IDX_W'(s);
        always_ff @(posedge clk) begin
            if (rst) begin
                dat_q[s] <= '0;
                len_q[s] <= '0;
                cs_q[s]  <= '0;
                dly_q[s] <= '0;
            end else if (wr_en && wr_idx == SLOT) begin
                dat_q[s] <= wr_data;
                len_q[s] <= wr_len;
                cs_q[s]  <= wr_cs;
                dly_q[s] <= wr_dly;
            end else if (wb_en && eng_idx == SLOT) begin
                dat_q[s] <= wb_data;
            end
        end
    end

    assign rd_data  = dat_q[rd_idx];
    assign eng_data = dat_q[eng_idx];
    assign eng_len  = len_q[eng_idx];
    assign eng_cs   = cs_q[eng_idx];
    assign eng_dly  = dly_q[eng_idx];

endmodule

// File: rtl/qspi_shift.sv
module qspi_shift #(
    parameter int DATA_W = 16,
    parameter int LEN_W  = 4,
    parameter int HALF   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [DATA_W-1:0] tx,
    input  logic [LEN_W-1:0]  len_m1,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              done,
    output logic [DATA_W-1:0] rx
);

    localparam int DIV_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF - 1);
    localparam logic [LEN_W-1:0] TOP_BIT  = LEN_W'(DATA_W - 1);

    logic              active;
    logic [DATA_W-1:0] sh;
    logic [LEN_W-1:0]  left;
    logic [DIV_W-1:0]  div;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            sh     <= '0;
            rx     <= '0;
            left   <= '0;
            div    <= '0;
            sclk   <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (go) begin
                    active <= 1'b1;
                    sh     <= tx << (TOP_BIT - len_m1);
                    rx     <= '0;
                    left   <= len_m1;
                    div    <= DIV_LAST;
                    sclk   <= 1'b0;
                end
            end else if (div != '0) begin
                div <= div - 1'b1;
            end else begin
                div <= DIV_LAST;
                if (!sclk) begin
                    sclk <= 1'b1;
                    rx   <= {rx[DATA_W-2:0], miso};
                end else begin
                    sclk <= 1'b0;
                    if (left == '0) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end else begin
                        left <= left - 1'b1;
                        sh   <= {sh[DATA_W-2:0], 1'b0};
                    end
                end
            end
        end
    end

    assign mosi = active & sh[DATA_W-1];

endmodule

// File: rtl/qspi_seq.sv
module qspi_seq
    import qspi_pkg::*;
#(
    parameter int IDX_W  = 4,
    parameter int CS_W   = 2,
    parameter int NUM_CS = 4,
    parameter int DLY_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              stop,
    input  logic              wrap_en,
    input  logic [IDX_W-1:0]  last_idx,
    input  logic [CS_W-1:0]   ent_cs,
    input  logic [DLY_W-1:0]  ent_dly,
    input  logic              shift_done,
    output logic [IDX_W-1:0]  idx,
    output logic              go,
    output logic              wb_en,
    output logic [NUM_CS-1:0] cs_n,
    output logic              busy,
    output logic              done,
    output logic              wrap_pulse
);

    seq_st_t          st;
    logic [DLY_W-1:0] gap;
    logic             stop_req;
    logic             halt_now;

    assign halt_now = stop_req | stop;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= SQ_IDLE;
            idx        <= '0;
            cs_n       <= '1;
            gap        <= '0;
            stop_req   <= 1'b0;
            done       <= 1'b0;
            wrap_pulse <= 1'b0;
        end else begin
            wrap_pulse <= 1'b0;
            if (stop && st != SQ_IDLE) stop_req <= 1'b1;
            case (st)
                SQ_IDLE: begin
                    if (start) begin
                        idx      <= '0;
                        stop_req <= 1'b0;
                        done     <= 1'b0;
                        st       <= SQ_LOAD;
                    end
                end
                SQ_LOAD: begin
                    for (int c = 0; c < NUM_CS; c++) begin
                        cs_n[c] <= (ent_cs != CS_W'(c));
                    end
                    st <= SQ_XFER;
                end
                SQ_XFER: begin
                    if (shift_done) begin
                        cs_n <= '1;
                        gap  <= ent_dly;
                        st   <= SQ_GAP;
                    end
                end
                SQ_GAP: begin
                    if (gap != '0) begin
                        gap <= gap - 1'b1;
                    end else if (halt_now) begin
                        st <= SQ_IDLE;
                    end else if (idx == last_idx) begin
                        if (wrap_en) begin
                            idx        <= '0;
                            wrap_pulse <= 1'b1;
                            st         <= SQ_LOAD;
                        end else begin
                            done <= 1'b1;
                            st   <= SQ_IDLE;
                        end
                    end else begin
                        idx <= idx + 1'b1;
                        st  <= SQ_LOAD;
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    assign go    = (st == SQ_LOAD);
    assign wb_en = (st == SQ_XFER) && shift_done;
    assign busy  = (st != SQ_IDLE);

endmodule

// File: rtl/qspi_ctrl.sv
module qspi_ctrl
    import qspi_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 16,
    parameter int NUM_CS = 4,
    parameter int DLY_W  = 8,
    parameter int HALF   = 4,
    localparam int IDX_W = idx_bits(DEPTH),
    localparam int LEN_W = idx_bits(DATA_W),
    localparam int CS_W  = idx_bits(NUM_CS),
    localparam int ENT_W = DLY_W + CS_W + LEN_W + DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [IDX_W-1:0]  host_addr,
    input  logic [ENT_W-1:0]  host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              start,
    input  logic              stop,
    input  logic              wrap_en,
    input  logic [IDX_W-1:0]  last_idx,
    output logic              busy,
    output logic              done,
    output logic              wrap_pulse,
    output logic              wr_err,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_CS-1:0] cs_n
);

    logic [IDX_W-1:0]  eng_idx;
    logic [DATA_W-1:0] eng_data;
    logic [LEN_W-1:0]  eng_len;
    logic [CS_W-1:0]   eng_cs;
    logic [DLY_W-1:0]  eng_dly;
    logic              go;
    logic              wb_en;
    logic              shift_done;
    logic [DATA_W-1:0] rx_word;
    logic              host_ok;

    assign host_ok = host_we & ~busy;

    qspi_queue #(
        .DEPTH(DEPTH), .DATA_W(DATA_W), .LEN_W(LEN_W),
        .CS_W(CS_W), .DLY_W(DLY_W), .IDX_W(IDX_W)
    ) i_queue (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (host_ok),
        .wr_idx  (host_addr),
        .wr_data (host_wdata[DATA_W-1:0]),
        .wr_len  (host_wdata[DATA_W +: LEN_W]),
        .wr_cs   (host_wdata[DATA_W+LEN_W +: CS_W]),
        .wr_dly  (host_wdata[DATA_W+LEN_W+CS_W +: DLY_W]),
        .rd_idx  (host_addr),
        .rd_data (host_rdata),
        .eng_idx (eng_idx),
        .eng_data(eng_data),
        .eng_len (eng_len),
        .eng_cs  (eng_cs),
        .eng_dly (eng_dly),
        .wb_en   (wb_en),
        .wb_data (rx_word)
    );

    qspi_seq #(
        .IDX_W(IDX_W), .CS_W(CS_W), .NUM_CS(NUM_CS), .DLY_W(DLY_W)
    ) i_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .stop      (stop),
        .wrap_en   (wrap_en),
        .last_idx  (last_idx),
        .ent_cs    (eng_cs),
        .ent_dly   (eng_dly),
        .shift_done(shift_done),
        .idx       (eng_idx),
        .go        (go),
        .wb_en     (wb_en),
        .cs_n      (cs_n),
        .busy      (busy),
        .done      (done),
        .wrap_pulse(wrap_pulse)
    );

    qspi_shift #(
        .DATA_W(DATA_W), .LEN_W(LEN_W), .HALF(HALF)
    ) i_shift (
        .clk   (clk),
        .rst   (rst),
        .go    (go),
        .tx    (eng_data),
        .len_m1(eng_len),
        .miso  (miso),
        .sclk  (sclk),
        .mosi  (mosi),
        .done  (shift_done),
        .rx    (rx_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_err <= 1'b0;
        end else if (start && !busy) begin
            wr_err <= 1'b0;
        end else if (host_we && busy) begin
            wr_err <= 1'b1;
        end
    end

endmodule

// File: rtl/qspi_ctrl_chk.sv
module qspi_ctrl_chk #(
    parameter int NUM_CS = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_CS-1:0] cs_n,
    input logic              sclk,
    input logic              busy,
    input logic              done,
    input logic              wrap_pulse,
    input logic              wr_err,
    input logic              host_we
);

    a_r1_reset_deselect: assert property (@(posedge clk)
        rst |=> (&cs_n && !busy && !sclk));

    a_r4_one_select: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n));

    a_r7_idle_deselect: assert property (@(posedge clk) disable iff (rst)
        !busy |-> &cs_n);

    a_r3_clock_idle_low: assert property (@(posedge clk) disable iff (rst)
        &cs_n |-> !sclk);

    a_r7_done_when_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r8_pass_not_done: assert property (@(posedge clk) disable iff (rst)
        wrap_pulse |-> (busy && !done));

    a_r10_err_on_busy_write: assert property (@(posedge clk) disable iff (rst)
        (host_we && busy) |=> wr_err);

endmodule

bind qspi_ctrl qspi_ctrl_chk #(.NUM_CS(NUM_CS)) i_qspi_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .busy      (busy),
    .done      (done),
    .wrap_pulse(wrap_pulse),
    .wr_err    (wr_err),
    .host_we   (host_we)
);

// File: tb/test_qspi_ctrl.sv
module test_qspi_ctrl;

    localparam int DW = 8, DEP = 4, NCS = 4, DLW = 4, HALF = 2;
    localparam int IW = 2, LW = 3, CW = 2, EW = DLW + CW + LW + DW;

    logic          clk = 1'b0;
    logic          rst;
    logic          host_we;
    logic [IW-1:0] host_addr;
    logic [EW-1:0] host_wdata;
    logic [DW-1:0] host_rdata;
    logic          start, stop, wrap_en;
    logic [IW-1:0] last_idx;
    logic          busy, done, wrap_pulse, wr_err;
    logic          sclk, mosi;
    logic          miso = 1'b0;
    logic [NCS-1:0] cs_n;

    always #5 clk = ~clk;

    qspi_ctrl #(.DEPTH(DEP), .DATA_W(DW), .NUM_CS(NCS), .DLY_W(DLW), .HALF(HALF)) i_qspi_ctrl (
        .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .start(start), .stop(stop),
        .wrap_en(wrap_en), .last_idx(last_idx), .busy(busy), .done(done),
        .wrap_pulse(wrap_pulse), .wr_err(wr_err), .sclk(sclk), .mosi(mosi),
        .miso(miso), .cs_n(cs_n)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // peripheral model and observers
    logic       sel;
    assign sel = ~&cs_n;
    int         xc = 0;
    int         bitpos = 0;
    logic [7:0] resp = '0;
    logic [7:0] cap = '0;
    int         nb = 0;
    logic [3:0] cur_cs = '1;
    logic       csbad = 1'b0;
    int         log_n [64];
    logic [7:0] log_mosi [64];
    logic [3:0] log_cs [64];
    logic       log_bad [64];
    int         log_gap [64];
    int         gidx = 0;
    int         gapcnt = 0;
    logic       sel_d = 1'b0;
    int         wraps = 0;

    function automatic logic [7:0] resp_of(input int k);
        return 8'((k * 53 + 29) % 256);
    endfunction

    always @(posedge sel) begin
        resp = resp_of(xc); bitpos = 7; miso = resp[7];
        cap = '0; nb = 0; cur_cs = cs_n; csbad = 1'b0;
    end
    always @(negedge sclk) if (sel) begin
        bitpos = bitpos - 1;
        miso = (bitpos >= 0) ? resp[bitpos] : 1'b0;
    end
    always @(posedge sclk) begin
        cap = {cap[6:0], mosi}; nb = nb + 1;
        if (cs_n != cur_cs || !sel) csbad = 1'b1;
    end
    always @(negedge sel) begin
        if (xc >= 0 && xc < 64) begin
            log_n[xc] = nb; log_mosi[xc] = cap; log_cs[xc] = cur_cs; log_bad[xc] = csbad;
        end
        xc = xc + 1;
    end
    always @(negedge clk) begin
        if (!busy) gapcnt = 0;
        else if (&cs_n) gapcnt = gapcnt + 1;
        if (sel === 1'b1 && sel_d === 1'b0 && gidx < 64) begin
            log_gap[gidx] = gapcnt; gidx = gidx + 1; gapcnt = 0;
        end
        sel_d = sel;
        if (wrap_pulse === 1'b1) wraps = wraps + 1;
    end

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc == 150000) begin
            checks = checks + 1; errors = errors + 1;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cyc);
            summary();
            $finish;
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic prog(input int i, input logic [7:0] d, input int len, input int c, input int dl);
        host_we = 1'b1; host_addr = IW'(i);
        host_wdata = {DLW'(dl), CW'(c), LW'(len - 1), d};
        tick();
        host_we = 1'b0;
    endtask

    function automatic int rd_slot(input int i);
        return 0;
    endfunction

    task automatic read_slot(input int i, output int v);
        host_addr = IW'(i); #1; v = int'(host_rdata);
    endtask

    task automatic wait_idle();
        tick();
        while (busy) tick();
    endtask

    function automatic logic [7:0] lmask(input int len);
        return 8'(8'hFF >> (8 - len));
    endfunction

    initial begin
        logic [7:0] cur [4];
        int ln [4], cs [4], dl [4];
        int v;
        rst = 1'b1; host_we = 1'b0; host_addr = '0; host_wdata = '0;
        start = 1'b0; stop = 1'b0; wrap_en = 1'b0; last_idx = '0;
        repeat (3) tick();
        chk("R1", "cs_n in reset", int'(cs_n), 15);
        rst = 1'b0;
        tick();
        chk("R1", "cs_n after reset", int'(cs_n), 15);
        chk("R1", "sclk after reset", int'(sclk), 0);
        chk("R1", "busy after reset", int'(busy), 0);
        chk("R1", "done after reset", int'(done), 0);
        chk("R1", "wr_err after reset", int'(wr_err), 0);

        // sweep: lengths, selects, delays, last indices
        for (int r = 0; r < 8; r++) begin
            int last;
            last = r % 4;
            for (int i = 0; i < 4; i++) begin
                cur[i] = 8'((r * 71 + i * 29 + 13) % 256);
                ln[i]  = ((r + i) % 8) + 1;
                cs[i]  = (r + 3 * i) % 4;
                dl[i]  = (r * 5 + i * 7) % 16;
                prog(i, cur[i], ln[i], cs[i], dl[i]);
            end
            for (int i = 0; i < 4; i++) begin
                read_slot(i, v);
                chk("R2", "slot readback after write", v, int'(cur[i]));
            end
            tick();
            xc = 0; gidx = 0; wraps = 0;
            last_idx = IW'(last); wrap_en = 1'b0; start = 1'b1;
            tick();
            start = 1'b0;
            chk("R7", "busy after start", int'(busy), 1);
            chk("R7", "done cleared by start", int'(done), 0);
            wait_idle();
            chk("R7", "transfers in run", xc, last + 1);
            chk("R7", "done after one-shot run", int'(done), 1);
            chk("R8", "no pass pulse in one-shot", wraps, 0);
            for (int k = 0; k <= last; k++) begin
                logic [7:0] exp_rx;
                chk("R3", "clock pulses", log_n[k], ln[k]);
                chk("R3", "bits sent", int'(log_mosi[k] & lmask(ln[k])), int'(cur[k] & lmask(ln[k])));
                chk("R4", "select pattern", int'(log_cs[k]), int'(4'hF & ~(4'h1 << cs[k])));
                chk("R4", "select held over word", int'(log_bad[k]), 0);
                if (k > 0) chk("R6", "select-high gap", log_gap[k], dl[k-1] + 2);
                exp_rx = resp_of(k) >> (8 - ln[k]);
                read_slot(k, v);
                chk("R5", "received word in slot", v, int'(exp_rx));
            end
            for (int k = last + 1; k < 4; k++) begin
                read_slot(k, v);
                chk("R7", "slot beyond last untouched", v, int'(cur[k]));
            end
        end

        // wrap mode with mid-word stop and busy write
        ln[0] = 8; cs[0] = 2; dl[0] = 1; cur[0] = 8'hA5;
        ln[1] = 5; cs[1] = 1; dl[1] = 3; cur[1] = 8'h3C;
        prog(0, cur[0], ln[0], cs[0], dl[0]);
        prog(1, cur[1], ln[1], cs[1], dl[1]);
        tick();
        xc = 0; gidx = 0; wraps = 0;
        last_idx = 2'd1; wrap_en = 1'b1; start = 1'b1;
        tick();
        start = 1'b0;
        while (gidx < 6) tick();
        tick(); tick();
        chk("R8", "done low while wrapping", int'(done), 0);
        host_we = 1'b1; host_addr = 2'd0; host_wdata = {4'd0, 2'd0, 3'd7, 8'hFF};
        tick();
        host_we = 1'b0;
        chk("R10", "error flag after busy write", int'(wr_err), 1);
        stop = 1'b1;
        tick();
        stop = 1'b0;
        wait_idle();
        chk("R9", "transfers before stop", xc, 6);
        chk("R9", "done after stop", int'(done), 0);
        chk("R8", "pass pulses", wraps, 2);
        for (int k = 0; k < 6; k++) begin
            int e;
            e = k % 2;
            chk("R9", "full word length", log_n[k], ln[e]);
            chk("R8", "wrap order select", int'(log_cs[k]), int'(4'hF & ~(4'h1 << cs[e])));
            chk("R8", "resent word", int'(log_mosi[k] & lmask(ln[e])), int'(cur[e] & lmask(ln[e])));
            if (k > 0) chk("R6", "gap across wrap", log_gap[k], dl[1 - e] + 2);
            cur[e] = resp_of(k) >> (8 - ln[e]);
        end
        read_slot(0, v);
        chk("R10", "slot 0 not overwritten while busy", v, int'(cur[0]));
        read_slot(1, v);
        chk("R5", "slot 1 after wrap run", v, int'(cur[1]));

        // new start clears the error flag
        tick();
        xc = 0; gidx = 0; wraps = 0;
        last_idx = 2'd0; wrap_en = 1'b0; start = 1'b1;
        tick();
        start = 1'b0;
        chk("R10", "error flag cleared by start", int'(wr_err), 0);
        wait_idle();
        chk("R7", "single-slot run count", xc, 1);
        chk("R7", "done after single-slot run", int'(done), 1);

        summary();
        $finish;
    end

endmodule